// File: doc/BRIEF.md
# UART Baud-Rate Prescaler

This block produces the baud tick for one UART channel. It divides the cycles on which a selected source is enabled by a programmable 11-bit value. Each time the count runs out it emits a single-cycle tick, so the baud rate is the source rate divided by (value + 1). Software sets the block up through two byte-wide registers: a control byte and a reload byte. The control byte holds a run bit, a source-select bit and the three upper bits of the division value. The reload byte holds the eight lower bits.

A self-clearing bit in the control byte issues a one-cycle reset pulse to the UART core and restarts the prescaler count. Both clock sources arrive as enable strobes synchronous to the block clock, so the whole block stays in one clock domain. Each channel is a separate instance. Address decoding reduces to a single register-select input.

Top module: `baud_prescaler`

## Requirements
- R1: After reset, the control byte (reg_sel=1) and the reload byte (reg_sel=0) both read 0x00, and baud_tick and uart_rst are low.
- R2: Control bit 7 is the run bit. While it is 0, no tick is produced. When it is set, the count restarts from the full division value N, and the first tick comes N+1 enabled source cycles after the write.
- R3: The division value N is {control[2:0], reload[7:0]}. While running, baud_tick is high for one cycle every N+1 enabled source cycles. The tick appears in the clock cycle that follows the enabled cycle on which the count is zero.
- R4: With N = 0, a tick follows every enabled source cycle.
- R5: Control bit 5 selects the source: 0 counts the cycles where src_a is high, and 1 counts the cycles where src_b is high. Cycles where the selected source is low do not advance the count.
- R6: Writing 1 to control bit 6 drives uart_rst high for exactly one cycle, starting in the cycle after the write. The bit reads 1 in that cycle and 0 afterwards. Writing 0 to it produces no pulse.
- R7: Control bits 4 and 3 are reserved: they always read 0, and writes to them are ignored.
- R8: While running, a write to either part of the division value leaves the count in progress untouched. The new value is used from the next reload point on.
- R9: While stopped, a new division value is loaded into the counter at once, so the first interval after a later start uses it.
- R10: A forced-reset write also reloads the counter with the division value, so the next tick comes N+1 enabled cycles after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 1 control byte, 0 reload byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| src_a | input | 1 | Enable strobe of clock source 0 |
| src_b | input | 1 | Enable strobe of clock source 1 |
| baud_tick | output | 1 | One-cycle baud tick |
| uart_rst | output | 1 | One-cycle forced reset toward the UART core |

## Verification
The assertions check the following on every cycle:
- the forced-reset pulse follows each reset write and lasts a single cycle;
- no tick appears while the prescaler is stopped;
- every tick is preceded by an enabled cycle of the selected source;
- the reserved bits read 0;
- tick and reset are quiet right after reset.

Only the bench scenarios can show the following, because each one depends on counting a whole interval:
- the actual tick spacing for several division values, including the split upper bits and N = 0;
- the deferred use of a value written mid-count;
- the immediate load while stopped;
- the restart of the count on a forced reset.

// File: rtl/bprs_pkg.sv
package bprs_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_SRC  = 2;
    localparam int SRC_SEL_W = $clog2(NUM_SRC);

    // control byte bit positions (decoded by the register block and software)
    localparam int CTL_RUN  = 7;
    localparam int CTL_SRST = 6;
    localparam int CTL_SRC  = 5;
    localparam int CTL_RSV_HI = 4;
    localparam int CTL_RSV_LO = 3;

    typedef enum logic {
        SEL_RELOAD = 1'b0,
        SEL_CTRL   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic       run;
        logic       srst;
        logic       src;
    } ctl_flags_t;

    function automatic ctl_flags_t flags_from_byte(input logic [BYTE_W-1:0] b);
        ctl_flags_t f;
        f.run  = b[CTL_RUN];
        f.srst = b[CTL_SRST];
        f.src  = b[CTL_SRC];
        return f;
    endfunction

endpackage

// File: rtl/bprs_regs.sv
module bprs_regs
    import bprs_pkg::*;
#(
    parameter int HI_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output ctl_flags_t        flags_q,
    output logic [HI_W+BYTE_W-1:0] div_q,
    output logic [HI_W+BYTE_W-1:0] div_nxt,
    output logic              force_load
);

    logic            ctl_we;
    logic            rld_we;
    ctl_flags_t      wr_flags;
    logic [HI_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;
    logic            unused_rsvd;

    assign ctl_we   = wr && (reg_sel_e'(sel) == SEL_CTRL);
    assign rld_we   = wr && (reg_sel_e'(sel) == SEL_RELOAD);
    assign wr_flags = flags_from_byte(wdata);
    assign unused_rsvd = ^wdata[CTL_RSV_HI:CTL_RSV_LO];

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            flags_q.srst <= 1'b0;
            if (ctl_we) begin
                flags_q.run  <= wr_flags.run;
                flags_q.srst <= wr_flags.srst;
                flags_q.src  <= wr_flags.src;
                hi_q         <= wdata[HI_W-1:0];
            end
            if (rld_we) begin
                lo_q <= wdata;
            end
        end
    end

    assign div_q      = {hi_q, lo_q};
    assign div_nxt    = {(ctl_we ? wdata[HI_W-1:0] : hi_q), (rld_we ? wdata : lo_q)};
    assign force_load = ctl_we && wr_flags.srst;

    always_comb begin
        rdata = '0;
        if (reg_sel_e'(sel) == SEL_CTRL) begin
            rdata[CTL_RUN]    = flags_q.run;
            rdata[CTL_SRST]   = flags_q.srst;
            rdata[CTL_SRC]    = flags_q.src;
            rdata[HI_W-1:0]   = hi_q;
        end else begin
            rdata = lo_q;
        end
    end

endmodule

// File: rtl/bprs_src_mux.sv
module bprs_src_mux
    import bprs_pkg::*;
(
    input  logic [NUM_SRC-1:0]   src_en,
    input  logic [SRC_SEL_W-1:0] sel,
    output logic                 en
);

    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = src_en[i] && (sel == SRC_SEL_W'(i));
    end

    assign en = |hit;

endmodule

// File: rtl/bprs_counter.sv
module bprs_counter #(
    parameter int DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             src_en,
    input  logic             force_load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] reload_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= run && src_en && at_zero;
            if (force_load || !run) begin
                cnt_q <= load_val;
            end else if (src_en) begin
                cnt_q <= at_zero ? reload_val : cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import bprs_pkg::*;
#(
    parameter int DIV_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              src_a,
    input  logic              src_b,
    output logic              baud_tick,
    output logic              uart_rst
);

    localparam int HI_W = DIV_W - BYTE_W;

    ctl_flags_t       flags_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_nxt;
    logic             force_load;
    logic             run_q;
    logic             sel_en;

    bprs_regs #(.HI_W(HI_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .flags_q    (flags_q),
        .div_q      (div_q),
        .div_nxt    (div_nxt),
        .force_load (force_load)
    );

    bprs_src_mux u_mux (
        .src_en ({src_b, src_a}),
        .sel    (flags_q.src),
        .en     (sel_en)
    );

    assign run_q = flags_q.run;

    bprs_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (run_q),
        .src_en     (sel_en),
        .force_load (force_load),
        .load_val   (div_nxt),
        .reload_val (div_q),
        .tick       (baud_tick)
    );

    assign uart_rst = flags_q.srst;

endmodule

// File: rtl/bprs_checker.sv
module bprs_checker (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic       wr_rst_bit,
    input logic [1:0] rd_rsvd,
    input logic       baud_tick,
    input logic       uart_rst,
    input logic       run_q,
    input logic       sel_en
);

    logic rst_write;
    assign rst_write = reg_wr && reg_sel && wr_rst_bit;

    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!baud_tick && !uart_rst));

    // R6
    a_r6_pulse_follows_write: assert property (@(posedge clk) disable iff (rst)
        rst_write |=> uart_rst);

    // R6
    a_r6_pulse_single: assert property (@(posedge clk) disable iff (rst)
        (uart_rst && !rst_write) |=> !uart_rst);

    // R2
    a_r2_stopped_silent: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> !baud_tick);

    // R5
    a_r5_tick_needs_source: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> $past(sel_en && run_q));

    // R7
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> (rd_rsvd == 2'b00));

endmodule

bind baud_prescaler bprs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .wr_rst_bit (reg_wdata[6]),
    .rd_rsvd    (reg_rdata[4:3]),
    .baud_tick  (baud_tick),
    .uart_rst   (uart_rst),
    .run_q      (run_q),
    .sel_en     (sel_en)
);

// File: tb/sim_baud_prescaler.sv
`timescale 1ns/1ps
module sim_baud_prescaler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       src_a = 1'b1;
    logic       src_b;
    logic       baud_tick;
    logic       uart_rst;
    int         bph = 0;
    int         errs = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) bph <= (bph == 2) ? 0 : bph + 1;
    assign src_b = (bph == 0);

    baud_prescaler u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_a(src_a),
        .src_b(src_b), .baud_tick(baud_tick), .uart_rst(uart_rst)
    );

    function automatic logic [7:0] cbyte(input bit run, input bit srst, input bit src, input logic [2:0] hi);
        return {run, srst, src, 2'b00, hi};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input bit sel, output logic [7:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!baud_tick && n < 5000);
    endtask

    task automatic run_with(input int div, input bit src);
        wr(1'b1, cbyte(0, 0, src, div[10:8]));
        wr(1'b0, div[7:0]);
        wr(1'b1, cbyte(1, 0, src, div[10:8]));
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(1'b1, d); chk(d == 8'h00, "R1 ctrl", d, 0);
        rd(1'b0, d); chk(d == 8'h00, "R1 reload", d, 0);
        chk(!baud_tick && !uart_rst, "R1 outputs", {baud_tick, uart_rst}, 0);
    endtask

    task automatic t_divide(input int div, input string tag);
        int n;
        run_with(div, 0);   // R9: value written while stopped is used at start
        wait_tick(n); chk(n == div + 1, {tag, " first"}, n, div + 1);
        wait_tick(n); chk(n == div + 1, {tag, " period"}, n, div + 1);
        wait_tick(n); chk(n == div + 1, {tag, " period2"}, n, div + 1);
    endtask

    task automatic t_stop;
        int cnt = 0;
        wr(1'b1, cbyte(0, 0, 0, 3'd0));
        @(posedge clk); @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); @(negedge clk);
            if (baud_tick) cnt++;
        end
        chk(cnt == 0, "R2 stopped ticks", cnt, 0);
    endtask

    task automatic t_deferred;
        int n;
        run_with(20, 0);
        wait_tick(n);
        wait_tick(n);
        wr(1'b0, 8'd3);
        wait_tick(n); chk(n + 1 == 21, "R8 current interval", n + 1, 21);
        wait_tick(n); chk(n == 4, "R8 new interval", n, 4);
    endtask

    task automatic t_source_b;
        int n;
        run_with(2, 1);
        wait_tick(n);
        wait_tick(n); chk(n == 9, "R5 src_b interval", n, 9);
        wait_tick(n); chk(n == 9, "R5 src_b interval2", n, 9);
    endtask

    task automatic t_force;
        logic [7:0] d;
        int n;
        wr(1'b1, cbyte(0, 0, 0, 3'd0));
        wr(1'b1, cbyte(0, 1, 0, 3'd0));
        rd(1'b1, d);
        chk(uart_rst == 1'b1, "R6 pulse high", uart_rst, 1);
        chk(d[6] == 1'b1, "R6 bit during pulse", d[6], 1);
        @(posedge clk); @(negedge clk);
        rd(1'b1, d);
        chk(uart_rst == 1'b0, "R6 pulse one cycle", uart_rst, 0);
        chk(d[6] == 1'b0, "R6 bit self-clears", d[6], 0);
        wr(1'b1, cbyte(0, 0, 0, 3'd0));
        chk(uart_rst == 1'b0, "R6 zero write no pulse", uart_rst, 0);
        run_with(30, 0);
        wait_tick(n);
        repeat (5) begin @(posedge clk); @(negedge clk); end
        wr(1'b1, cbyte(1, 1, 0, 3'd0));
        wait_tick(n); chk(n == 31, "R10 reload on reset", n, 31);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        wr(1'b1, 8'h1D);
        rd(1'b1, d); chk(d == 8'h05, "R7 reserved bits", d, 5);
        wr(1'b1, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_divide(5, "R3 N=5");
        t_divide(1234, "R3 split N=1234");
        t_divide(0, "R4 N=0");
        t_stop();
        t_deferred();
        t_source_b();
        t_force();
        t_reserved();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule